// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits in the decode/issue stage of an in-order pipeline. That pipeline drives several floating-point execution units, and each unit has its own result latency and its own repeat-issue interval. Every cycle the block receives one decoded instruction: a valid flag, a unit class, a destination register and two source registers. In the same cycle it decides whether the instruction may leave decode. If it may not, it names the hazard that holds it back.

The block keeps two sets of down-counters:
- one per execution unit, covering the cycles left before that unit accepts another operation;
- one per architectural register, covering the cycles left until a pending result lands.

Because issue is in order but units differ in speed, results can complete out of order. The block therefore checks three hazards together: the target unit still busy, a source still awaiting its value, and a destination whose older write would land after the new one. A stalled instruction changes nothing, and the front end holds it (and everything behind it) until the interlock lets it go. Register 0 is a constant register and never carries a pending write.

Top module: `fpil_issue_interlock`

## Requirements
- R1: While `dec_valid` is low, `issue_go` is 0 and `stall_cause` is 0; the counters only run down.
- R2: Unit class codes and timing (latency L, repeat interval I): 0 = add/subtract (L 4, I 3), 1 = multiply (L 8, I 4), 2 = divide (L 36, I 35), 3 = negate/absolute (L 2, I 1), 4 = compare (L 3, I 2).
- R3: After an issue to a unit in cycle t, a valid instruction to that unit stalls with `stall_cause` = 1 in cycles t+1 to t+I-1 and is free of structural stall from cycle t+I.
- R4: After an issue writing register d (d ≠ 0) with latency L in cycle t, a valid instruction reading d on either source stalls with cause 2 in cycles t+1 to t+L-1 and is free of that hazard from cycle t+L.
- R5: After an issue writing d (d ≠ 0) with latency Lo in cycle t, a valid instruction writing d with latency Ln stalls with cause 3 in cycle t+k (k ≥ 1) while Ln ≤ Lo-k+1.
- R6: Cause codes are 0 none, 1 structural, 2 RAW, 3 WAW. When several hazards coexist, the reported cause is the first of structural, RAW, WAW.
- R7: A stalled instruction leaves no unit or register occupied.
- R8: Register 0 used as source or destination never produces a RAW or WAW stall.
- R9: Synchronous reset clears every counter, so any instruction issues in the first cycle after reset.
- R10: An instruction on a different unit with unrelated registers issues in the cycle after a long-latency issue (out-of-order completion is permitted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_unit | input | 3 | Unit class code (R2) |
| dec_dst | input | $clog2(NUM_REGS) | Destination register |
| dec_src_a | input | $clog2(NUM_REGS) | First source register |
| dec_src_b | input | $clog2(NUM_REGS) | Second source register |
| issue_go | output | 1 | Instruction leaves decode this cycle |
| stall_cause | output | 2 | Stall reason code (R6) |

## Verification
The WAW case is the hard one to reach from the ports. It needs a fast write to a register that a slower write still owns, while neither the target unit nor any source blocks first. A busy unit or a RAW hit would mask it under the priority order.

The bench steers into this case with directed sequences:
- a multiply followed by a held negate or add to the same destination, with sources on register 0, walked to the exact release cycle;
- a divide chain that presents, one cycle after another, an instruction carrying all three hazards, then two hazards, then WAW alone.

A long random run then uses only eight registers and holds every stalled instruction. This produces overlapping hazards of all three kinds, and a behavioural model checks each one cycle by cycle.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

  localparam int UNIT_CNT = 5;
  localparam int UCLS_W   = 3;

  typedef enum logic [UCLS_W-1:0] {
    UC_ADD    = 3'd0,
    UC_MUL    = 3'd1,
    UC_DIV    = 3'd2,
    UC_SIMPLE = 3'd3,
    UC_CMP    = 3'd4
  } ucls_e;

  typedef enum logic [1:0] {
    WHY_NONE   = 2'd0,
    WHY_STRUCT = 2'd1,
    WHY_RAW    = 2'd2,
    WHY_WAW    = 2'd3
  } why_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpil_unit_timers.sv
module fpil_unit_timers #(
  parameter int NUNITS = 5,
  parameter int CNT_W  = 6,
  parameter logic [NUNITS*CNT_W-1:0] RELOAD_PACK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [NUNITS-1:0] load_sel,
  output logic [NUNITS-1:0] busy_o
);

  logic [CNT_W-1:0] left_q [NUNITS];

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    localparam logic [CNT_W-1:0] RELOAD = RELOAD_PACK[u*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        left_q[u] <= '0;
      end else if (load_en && load_sel[u]) begin
        left_q[u] <= RELOAD;
      end else if (left_q[u] != '0) begin
        left_q[u] <= left_q[u] - 1'b1;
      end
    end

    assign busy_o[u] = (left_q[u] != '0);

    // R3: the arbiter must never launch onto a unit that is still occupied
    assert_no_reload_busy_R3: assert property (@(posedge clk) disable iff (rst)
      (left_q[u] != '0) |-> !(load_en && load_sel[u]));
  end

endmodule

// File: rtl/fpil_pend_file.sv
module fpil_pend_file #(
  parameter int NREGS = 32,
  parameter int AW    = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [AW-1:0]    rd_a_idx,
  input  logic [AW-1:0]    rd_b_idx,
  input  logic [AW-1:0]    rd_d_idx,
  output logic [CNT_W-1:0] rd_a_cnt,
  output logic [CNT_W-1:0] rd_b_cnt,
  output logic [CNT_W-1:0] rd_d_cnt
);

  logic [CNT_W-1:0] pend_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[r] <= '0;
      end else if (wr_en && (wr_idx == AW'(r))) begin
        pend_q[r] <= wr_val;
      end else if (pend_q[r] != '0) begin
        pend_q[r] <= pend_q[r] - 1'b1;
      end
    end
  end

  assign rd_a_cnt = pend_q[rd_a_idx];
  assign rd_b_cnt = pend_q[rd_b_idx];
  assign rd_d_cnt = pend_q[rd_d_idx];

  // R8: the constant register never accumulates a pending write
  assert_zero_reg_idle_R8: assert property (@(posedge clk) disable iff (rst)
    pend_q[0] == '0);

  // R4: every loaded latency blocks a consumer in the very next cycle
  assert_wr_latency_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_val > CNT_W'(1)));

endmodule

// File: rtl/fpil_hazard_arb.sv
module fpil_hazard_arb
  import fpil_pkg::*;
#(
  parameter int AW    = 5,
  parameter int CNT_W = 6
) (
  input  logic             valid,
  input  logic             unit_busy,
  input  logic [AW-1:0]    src_a,
  input  logic [AW-1:0]    src_b,
  input  logic [AW-1:0]    dst,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] new_lat,
  output logic             go,
  output logic [1:0]       cause
);

  logic hz_struct, hz_raw, hz_waw;
  why_e why;

  always_comb begin
    hz_struct = unit_busy;
    hz_raw    = ((src_a != '0) && (cnt_a > CNT_W'(1))) ||
                ((src_b != '0) && (cnt_b > CNT_W'(1)));
    hz_waw    = (dst != '0) && (new_lat <= cnt_d);

    if (!valid)         why = WHY_NONE;
    else if (hz_struct) why = WHY_STRUCT;
    else if (hz_raw)    why = WHY_RAW;
    else if (hz_waw)    why = WHY_WAW;
    else                why = WHY_NONE;

    go    = valid && !hz_struct && !hz_raw && !hz_waw;
    cause = why;
  end

endmodule

// File: rtl/fpil_issue_interlock.sv
module fpil_issue_interlock
  import fpil_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADD_LAT  = 4,
  parameter int ADD_II   = 3,
  parameter int MUL_LAT  = 8,
  parameter int MUL_II   = 4,
  parameter int DIV_LAT  = 36,
  parameter int DIV_II   = 35,
  parameter int SMP_LAT  = 2,
  parameter int SMP_II   = 1,
  parameter int CMP_LAT  = 3,
  parameter int CMP_II   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        dec_valid,
  input  logic [2:0]                  dec_unit,
  input  logic [$clog2(NUM_REGS)-1:0] dec_dst,
  input  logic [$clog2(NUM_REGS)-1:0] dec_src_a,
  input  logic [$clog2(NUM_REGS)-1:0] dec_src_b,
  output logic                        issue_go,
  output logic [1:0]                  stall_cause
);

  localparam int AW      = $clog2(NUM_REGS);
  localparam int MAX_LAT = max2(max2(max2(ADD_LAT, MUL_LAT), max2(DIV_LAT, SMP_LAT)),
                                max2(CMP_LAT, max2(DIV_II, MUL_II)));
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  localparam logic [UNIT_CNT*CNT_W-1:0] LAT_PACK = {
    CNT_W'(CMP_LAT), CNT_W'(SMP_LAT), CNT_W'(DIV_LAT), CNT_W'(MUL_LAT), CNT_W'(ADD_LAT)};
  localparam logic [UNIT_CNT*CNT_W-1:0] RELOAD_PACK = {
    CNT_W'(CMP_II - 1), CNT_W'(SMP_II - 1), CNT_W'(DIV_II - 1),
    CNT_W'(MUL_II - 1), CNT_W'(ADD_II - 1)};

  logic [UNIT_CNT-1:0] unit_sel;
  logic [UNIT_CNT-1:0] unit_busy;
  logic [CNT_W-1:0]    new_lat;
  logic [CNT_W-1:0]    sel_reload;
  logic [CNT_W-1:0]    cnt_a, cnt_b, cnt_d;
  logic                busy_sel;
  logic                wr_en;

  // unit class decode and timing lookup
  always_comb begin
    new_lat    = CNT_W'(SMP_LAT);
    sel_reload = '0;
    for (int u = 0; u < UNIT_CNT; u++) begin
      unit_sel[u] = (dec_unit == UCLS_W'(u));
      if (unit_sel[u]) begin
        new_lat    = LAT_PACK[u*CNT_W +: CNT_W];
        sel_reload = RELOAD_PACK[u*CNT_W +: CNT_W];
      end
    end
    busy_sel = |(unit_busy & unit_sel);
  end

  fpil_unit_timers #(
    .NUNITS     (UNIT_CNT),
    .CNT_W      (CNT_W),
    .RELOAD_PACK(RELOAD_PACK)
  ) u_units (
    .clk     (clk),
    .rst     (rst),
    .load_en (issue_go),
    .load_sel(unit_sel),
    .busy_o  (unit_busy)
  );

  assign wr_en = issue_go && (dec_dst != '0);

  fpil_pend_file #(
    .NREGS(NUM_REGS),
    .AW   (AW),
    .CNT_W(CNT_W)
  ) u_pend (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (dec_dst),
    .wr_val  (new_lat),
    .rd_a_idx(dec_src_a),
    .rd_b_idx(dec_src_b),
    .rd_d_idx(dec_dst),
    .rd_a_cnt(cnt_a),
    .rd_b_cnt(cnt_b),
    .rd_d_cnt(cnt_d)
  );

  fpil_hazard_arb #(
    .AW   (AW),
    .CNT_W(CNT_W)
  ) u_arb (
    .valid    (dec_valid),
    .unit_busy(busy_sel),
    .src_a    (dec_src_a),
    .src_b    (dec_src_b),
    .dst      (dec_dst),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .cnt_d    (cnt_d),
    .new_lat  (new_lat),
    .go       (issue_go),
    .cause    (stall_cause)
  );

  // R1: an empty decode slot neither issues nor reports a hazard
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!issue_go && stall_cause == 2'd0));

  // R3: back-to-back use of a unit with an interval above one is blocked
  assert_struct_next_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_go && sel_reload != '0) |=>
      (!dec_valid || dec_unit != $past(dec_unit) || stall_cause == 2'd1));

  // R4: a consumer of a fresh result one cycle later is held
  assert_raw_next_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_go && dec_dst != '0) |=>
      (!dec_valid || dec_src_a != $past(dec_dst) ||
       stall_cause == 2'd1 || stall_cause == 2'd2));

endmodule

// File: tb/test_fpil_issue_interlock.sv
module test_fpil_issue_interlock;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic [2:0] dec_unit = '0;
  logic [4:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
  logic       issue_go;
  logic [1:0] stall_cause;

  int n_run = 0;
  int n_fail = 0;
  int ub[5];
  int rr[32];

  always #5 clk = ~clk;

  fpil_issue_interlock i_fpil_issue_interlock (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .issue_go(issue_go), .stall_cause(stall_cause));

  function automatic int lat_of(input int u);
    case (u)
      0: return 4;  1: return 8;  2: return 36;  3: return 2;  default: return 3;
    endcase
  endfunction

  function automatic int ii_of(input int u);
    case (u)
      0: return 3;  1: return 4;  2: return 35;  3: return 1;  default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 5; i++) ub[i] = 0;
    for (int i = 0; i < 32; i++) rr[i] = 0;
  endtask

  // one decode cycle; want >= 0 adds a literal expectation on the cause
  task automatic step(input bit v, input int u, input int d, input int a, input int b,
                      input int want, input string tag, output bit went);
    int ec;
    bit s, r, w, eg;
    @(negedge clk);
    dec_valid = v; dec_unit = 3'(u); dec_dst = 5'(d); dec_src_a = 5'(a); dec_src_b = 5'(b);
    #1;
    s  = v && ub[u] != 0;
    r  = v && ((a != 0 && rr[a] > 1) || (b != 0 && rr[b] > 1));
    w  = v && d != 0 && lat_of(u) <= rr[d];
    ec = !v ? 0 : s ? 1 : r ? 2 : w ? 3 : 0;
    eg = v && ec == 0;
    check(stall_cause == 2'(ec), tag, "stall_cause(model)", stall_cause, ec);
    check(issue_go == eg, tag, "issue_go(model)", issue_go, eg);
    if (want >= 0) check(stall_cause == 2'(want), tag, "stall_cause(directed)", stall_cause, want);
    for (int i = 0; i < 5; i++) if (ub[i] > 0) ub[i]--;
    for (int i = 0; i < 32; i++) if (rr[i] > 0) rr[i]--;
    if (eg) begin
      ub[u] = ii_of(u) - 1;
      if (d != 0) rr[d] = lat_of(u);
    end
    went = eg;
  endtask

  task automatic idle(input int n);
    bit g;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "R1", g);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dec_valid = 1'b0;
    repeat (2) @(negedge clk);
    model_clear();
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit g;
    int cu, cd, ca, cb;
    bit cv;
    model_clear();
    do_reset();
    // R9 reset state: idle outputs, then a full-latency divide issues at once
    step(0, 0, 0, 0, 0, 0, "R9", g);
    step(1, 2, 1, 0, 0, 0, "R9", g);
    // R10 out-of-order completion: quick negate right behind the divide
    step(1, 3, 2, 3, 4, 0, "R10", g);
    idle(40);
    // R3 add unit interval 3 (R2 code 0)
    step(1, 0, 4, 0, 0, 0, "R3", g);
    step(1, 0, 5, 6, 7, 1, "R3", g);
    step(1, 0, 5, 6, 7, 1, "R3", g);
    step(1, 0, 5, 6, 7, 0, "R3", g);
    idle(40);
    // R4 multiply latency 8 (R2 code 1) feeding an add
    step(1, 1, 8, 0, 0, 0, "R4", g);
    for (int k = 1; k < 8; k++) step(1, 0, 9, 0, 8, 2, "R4", g);
    step(1, 0, 9, 0, 8, 0, "R4", g);
    idle(40);
    // R5 WAW boundary: negate after multiply to same register, release at k=8
    step(1, 1, 3, 0, 0, 0, "R5", g);
    for (int k = 1; k < 8; k++) step(1, 3, 3, 0, 0, 3, "R5", g);
    step(1, 3, 3, 0, 0, 0, "R5", g);
    idle(40);
    // R5 add after multiply: release at k=6
    step(1, 1, 3, 0, 0, 0, "R5", g);
    for (int k = 1; k < 6; k++) step(1, 0, 3, 0, 0, 3, "R5", g);
    step(1, 0, 3, 0, 0, 0, "R5", g);
    idle(40);
    // R6 priority: all three, then RAW+WAW, then WAW alone
    step(1, 2, 1, 0, 0, 0, "R6", g);
    step(1, 2, 1, 1, 0, 1, "R6", g);
    step(1, 0, 1, 0, 1, 2, "R6", g);
    step(1, 0, 1, 0, 0, 3, "R6", g);
    idle(40);
    // R8 register 0 as destination and source
    step(1, 3, 0, 0, 0, 0, "R8", g);
    step(1, 3, 0, 0, 0, 0, "R8", g);
    step(1, 4, 0, 0, 0, 0, "R8", g);
    idle(5);
    // R7 a stalled instruction leaves its destination and unit untouched
    step(1, 1, 5, 0, 0, 0, "R7", g);
    step(1, 0, 6, 5, 0, 2, "R7", g);
    step(1, 3, 7, 6, 6, 0, "R7", g);
    step(1, 0, 10, 0, 0, 0, "R7", g);
    idle(40);
    // R9 mid-run reset clears unit and register counters
    step(1, 2, 4, 0, 0, 0, "R9", g);
    do_reset();
    step(1, 2, 4, 4, 4, 0, "R9", g);
    idle(40);
    // random run with in-order hold on stall
    g = 1'b1;
    cv = 0; cu = 0; cd = 0; ca = 0; cb = 0;
    for (int i = 0; i < 4000; i++) begin
      string tg;
      if (g || !cv) begin
        cv = ($urandom % 5) != 0;
        cu = $urandom % 5;
        cd = $urandom % 8;
        ca = $urandom % 8;
        cb = $urandom % 8;
      end
      tg = !cv ? "R1" : (ub[cu] != 0) ? "R3" : "R4/R5/R10";
      step(cv, cu, cd, ca, cb, -1, tg, g);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule